// File: doc/BRIEF.md
# Matrix Keypad Scanner (4 x 4)

The scanner reads a sixteen-key switch matrix that is wired as four column drive lines and four row sense lines. The row lines have pull-ups on the board. The block pulls one column low at a time and leaves the other three high. It waits a programmable settle time and then looks at the rows. A row that reads low marks the key at that row/column crossing as closed. The row lines are asynchronous to the clock, so they pass through a two-flop synchronizer before the scanner uses them.

One full pass over the four columns is one scan. Each scan yields at most one candidate key. If several keys are down, the first one met in scan order wins. The debouncer accepts a key only when the same candidate has appeared on a set number of back-to-back scans. It then raises a one-cycle press pulse and holds the key number and its printable legend for as long as the key stays down. It drops them only after the same number of back-to-back empty scans. There is no auto-repeat: one press gives one pulse.

Top module: `kpd_matrix_scanner`

## Requirements
- R1: `col_n_o` bit c drives column c. At every cycle exactly one bit of `col_n_o` is 0. During and straight after reset, column 3 is the one driven low (`col_n_o` = 4'b0111).
- R2: The low column steps in the repeating order 3, 2, 1, 0, 3, and so on. Each column stays low for exactly SETTLE_CYC+1 clock cycles. One scan therefore lasts 4*(SETTLE_CYC+1) cycles.
- R3: The rows are active low. `row_n_i` bit r is row r and idles at 1. A 0 on row r while column c is low is key number r*4+c. The rows are synchronized through two flops and sampled in the last cycle of each column step.
- R4: `key_char_o` is the ASCII legend of `key_code_o`: 0='1', 1='2', 2='3', 3='A', 4='4', 5='5', 6='6', 7='B', 8='7', 9='8', 10='9', 11='C', 12='*', 13='0', 14='#', 15='D'.
- R5: A key is accepted only after it has been the scan result on DEBOUNCE_SCANS consecutive scans. A key closed for fewer scans produces no pulse and leaves `key_valid_o` low.
- R6: `press_pulse_o` is high for exactly one cycle per accepted press. It is high in the same cycle that `key_valid_o` rises.
- R7: While `key_valid_o` is high, `key_code_o` and `key_char_o` hold their value. A different key seen while one is held gives no new pulse and no code change.
- R8: A held key is released after DEBOUNCE_SCANS consecutive scans that find no key. After release, `key_valid_o` is 0, `key_code_o` is 0 and `key_char_o` is 8'h00.
- R9: With several keys down, the scan result is the key in the earliest-scanned column (higher column number first). Within that column the lowest row number wins.
- R10: After reset, `key_valid_o` and `press_pulse_o` are 0 and `key_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_n_i | input | 4 | Row sense lines, active low, pulled up |
| col_n_o | output | 4 | Column drive lines, one low at a time |
| key_valid_o | output | 1 | A debounced key is held |
| key_code_o | output | 4 | Held key number, row*4+column |
| key_char_o | output | 8 | ASCII legend of the held key, 0 when none |
| press_pulse_o | output | 1 | One-cycle pulse on each accepted press |

## Verification
A wrong column counter or settle counter shows up on `col_n_o` within one column step: two lines low, a skipped column, or a step of the wrong length. A wrong per-scan collector reports the wrong key, most visibly when several keys are down. A miscounting debouncer moves the press pulse outside its window of DEBOUNCE_SCANS scans, or lets a short bounce through. Both faults are visible at most DEBOUNCE_SCANS+1 scans after the stimulus. A held-state fault shows as a second pulse, or as a changed code while a key is held.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int NUM_COLS = 4;
  localparam int NUM_ROWS = 4;
  localparam int COL_W    = $clog2(NUM_COLS);
  localparam int ROW_W    = $clog2(NUM_ROWS);
  localparam int CODE_W   = COL_W + ROW_W;

  // key number from row and column: row*4 + column
  function automatic logic [CODE_W-1:0] key_number(input logic [ROW_W-1:0] row,
                                                   input logic [COL_W-1:0] col);
    return {row, col};
  endfunction

  // printable legend of a key number
  function automatic logic [7:0] key_legend(input logic [CODE_W-1:0] code);
    logic [7:0] ch;
    case (code)
      4'd0:  ch = "1";
      4'd1:  ch = "2";
      4'd2:  ch = "3";
      4'd3:  ch = "A";
      4'd4:  ch = "4";
      4'd5:  ch = "5";
      4'd6:  ch = "6";
      4'd7:  ch = "B";
      4'd8:  ch = "7";
      4'd9:  ch = "8";
      4'd10: ch = "9";
      4'd11: ch = "C";
      4'd12: ch = "*";
      4'd13: ch = "0";
      4'd14: ch = "#";
      default: ch = "D";
    endcase
    return ch;
  endfunction
endpackage

// File: rtl/kpd_row_sync.sv
module kpd_row_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  // idle level of pulled-up rows is all ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/kpd_col_seq.sv
module kpd_col_seq
  import kpd_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [NUM_COLS-1:0] col_n_o,
  output logic [COL_W-1:0]    col_idx_o,
  output logic                step_o,
  output logic                scan_end_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1) + 1;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  logic [CNT_W-1:0] settle_q;
  logic [COL_W-1:0] col_q;

  assign step_o     = (settle_q == CNT_W'(SETTLE_CYC));
  assign scan_end_o = step_o && (col_q == '0);
  assign col_idx_o  = col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      col_q    <= LAST_COL;
    end else if (step_o) begin
      settle_q <= '0;
      col_q    <= (col_q == '0) ? LAST_COL : col_q - 1'b1;
    end else begin
      settle_q <= settle_q + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_drive
    assign col_n_o[c] = (col_q != COL_W'(c));
  end
endmodule

// File: rtl/kpd_scan_collect.sv
module kpd_scan_collect
  import kpd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                scan_end_i,
  input  logic [COL_W-1:0]    col_idx_i,
  input  logic [NUM_ROWS-1:0] rows_n_i,
  output logic                res_valid_o,
  output logic                res_hit_o,
  output logic [CODE_W-1:0]   res_code_o
);
  logic                found_q;
  logic [CODE_W-1:0]   code_q;
  logic                hit_now;
  logic [ROW_W-1:0]    row_sel;

  assign hit_now = |(~rows_n_i);

  // lowest active row wins inside one column
  always_comb begin
    row_sel = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (!rows_n_i[r]) row_sel = ROW_W'(r);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q     <= 1'b0;
      code_q      <= '0;
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_code_o  <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (step_i) begin
        if (scan_end_i) begin
          res_valid_o <= 1'b1;
          res_hit_o   <= found_q | hit_now;
          res_code_o  <= found_q ? code_q : key_number(row_sel, col_idx_i);
          found_q     <= 1'b0;
          code_q      <= '0;
        end else if (!found_q && hit_now) begin
          found_q <= 1'b1;
          code_q  <= key_number(row_sel, col_idx_i);
        end
      end
    end
  end
endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce
  import kpd_pkg::*;
#(
  parameter int DEBOUNCE_SCANS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid_i,
  input  logic              res_hit_i,
  input  logic [CODE_W-1:0] res_code_i,
  output logic              key_valid_o,
  output logic [CODE_W-1:0] key_code_o,
  output logic              press_pulse_o
);
  localparam int CW = $clog2(DEBOUNCE_SCANS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEBOUNCE_SCANS);

  logic [CW-1:0]     press_cnt_q;
  logic [CW-1:0]     rel_cnt_q;
  logic [CODE_W-1:0] cand_q;
  logic [CW-1:0]     press_nxt;

  assign press_nxt = (press_cnt_q != '0 && res_code_i == cand_q) ? press_cnt_q + 1'b1
                                                                 : CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      press_cnt_q   <= '0;
      rel_cnt_q     <= '0;
      cand_q        <= '0;
      key_valid_o   <= 1'b0;
      key_code_o    <= '0;
      press_pulse_o <= 1'b0;
    end else begin
      press_pulse_o <= 1'b0;
      if (res_valid_i) begin
        if (!key_valid_o) begin
          if (res_hit_i) begin
            cand_q <= res_code_i;
            if (press_nxt == LIMIT) begin
              key_valid_o   <= 1'b1;
              key_code_o    <= res_code_i;
              press_pulse_o <= 1'b1;
              press_cnt_q   <= '0;
              rel_cnt_q     <= '0;
            end else begin
              press_cnt_q <= press_nxt;
            end
          end else begin
            press_cnt_q <= '0;
          end
        end else begin
          if (res_hit_i) begin
            rel_cnt_q <= '0;
          end else if (rel_cnt_q + 1'b1 == LIMIT) begin
            key_valid_o <= 1'b0;
            key_code_o  <= '0;
            rel_cnt_q   <= '0;
          end else begin
            rel_cnt_q <= rel_cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/kpd_matrix_scanner.sv
module kpd_matrix_scanner
  import kpd_pkg::*;
#(
  parameter int SETTLE_CYC     = 4,
  parameter int DEBOUNCE_SCANS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] row_n_i,
  output logic [3:0] col_n_o,
  output logic       key_valid_o,
  output logic [3:0] key_code_o,
  output logic [7:0] key_char_o,
  output logic       press_pulse_o
);
  // named internal events, visible to the checker
  logic [NUM_ROWS-1:0] rows_sync;
  logic [COL_W-1:0]    col_idx;
  logic                col_step;
  logic                scan_end;
  logic                scan_res_valid;
  logic                scan_res_hit;
  logic [CODE_W-1:0]   scan_res_code;

  kpd_row_sync #(.WIDTH(NUM_ROWS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (row_n_i),
    .sync_o  (rows_sync)
  );

  kpd_col_seq #(.SETTLE_CYC(SETTLE_CYC)) u_cols (
    .clk        (clk),
    .rst_n      (rst_n),
    .col_n_o    (col_n_o),
    .col_idx_o  (col_idx),
    .step_o     (col_step),
    .scan_end_o (scan_end)
  );

  kpd_scan_collect u_collect (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (col_step),
    .scan_end_i  (scan_end),
    .col_idx_i   (col_idx),
    .rows_n_i    (rows_sync),
    .res_valid_o (scan_res_valid),
    .res_hit_o   (scan_res_hit),
    .res_code_o  (scan_res_code)
  );

  kpd_debounce #(.DEBOUNCE_SCANS(DEBOUNCE_SCANS)) u_deb (
    .clk           (clk),
    .rst_n         (rst_n),
    .res_valid_i   (scan_res_valid),
    .res_hit_i     (scan_res_hit),
    .res_code_i    (scan_res_code),
    .key_valid_o   (key_valid_o),
    .key_code_o    (key_code_o),
    .press_pulse_o (press_pulse_o)
  );

  assign key_char_o = key_valid_o ? key_legend(key_code_o) : 8'h00;
endmodule

// File: rtl/kpd_matrix_scanner_chk.sv
module kpd_matrix_scanner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] col_n_o,
  input logic       col_step,
  input logic       key_valid_o,
  input logic [3:0] key_code_o,
  input logic [7:0] key_char_o,
  input logic       press_pulse_o
);
  a_r1_one_col_low: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~col_n_o) == 1);

  a_r2_col_held_in_step: assert property (@(posedge clk) disable iff (!rst_n)
    !col_step |=> $stable(col_n_o));

  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse_o |=> !press_pulse_o);

  a_r6_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse_o |-> (key_valid_o && !$past(key_valid_o)));

  a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid_o && $past(key_valid_o)) |-> ($stable(key_code_o) && $stable(key_char_o)));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid_o |-> (key_code_o == 4'd0 && key_char_o == 8'h00));
endmodule

bind kpd_matrix_scanner kpd_matrix_scanner_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .col_n_o       (col_n_o),
  .col_step      (col_step),
  .key_valid_o   (key_valid_o),
  .key_code_o    (key_code_o),
  .key_char_o    (key_char_o),
  .press_pulse_o (press_pulse_o)
);

// File: tb/sim_kpd_matrix_scanner.sv
`timescale 1ns/1ps
module sim_kpd_matrix_scanner;
  localparam int SETTLE = 4;
  localparam int DEB    = 3;
  localparam int SCAN   = 4 * (SETTLE + 1);
  localparam int WAITC  = (DEB + 2) * SCAN;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] row_n;
  logic [3:0] col_n;
  logic       kvalid;
  logic [3:0] kcode;
  logic [7:0] kchar;
  logic       kpulse;
  logic [15:0] pressed = '0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int pulses = 0;
  int last_pulse_cyc = 0;
  bit done = 1'b0;
  string legends = "123A456B789C*0#D";

  always #2 clk = ~clk;

  kpd_matrix_scanner #(.SETTLE_CYC(SETTLE), .DEBOUNCE_SCANS(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .row_n_i(row_n), .col_n_o(col_n),
    .key_valid_o(kvalid), .key_code_o(kcode), .key_char_o(kchar),
    .press_pulse_o(kpulse)
  );

  // matrix model: row r reads low if a closed key sits on a low column
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      logic low;
      low = 1'b0;
      for (int c = 0; c < 4; c++) low |= pressed[r*4+c] & ~col_n[c];
      row_n[r] = ~low;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && kpulse) begin
    pulses <= pulses + 1;
    last_pulse_cyc <= cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected winner under scan order: higher column first, then lower row
  function automatic int expect_key(input logic [15:0] m);
    for (int c = 3; c >= 0; c--)
      for (int r = 0; r < 4; r++)
        if (m[r*4+c]) return r*4 + c;
    return -1;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press_check(input logic [15:0] m, input string tag);
    int p0, t0, k;
    k = expect_key(m);
    @(negedge clk);
    p0 = pulses;
    t0 = cyc;
    pressed = m;
    wait_cyc(WAITC);
    chk(kvalid == 1'b1, {tag, " R5 valid"}, kvalid, 1);
    chk(kcode == 4'(k), {tag, " R3/R9 code"}, kcode, k);
    chk(kchar == legends[k], {tag, " R4 legend"}, kchar, legends[k]);
    chk(pulses == p0 + 1, {tag, " R6 one pulse"}, pulses - p0, 1);
    chk((last_pulse_cyc - t0 > (DEB - 1) * SCAN) && (last_pulse_cyc - t0 <= (DEB + 1) * SCAN + 8),
        {tag, " R5 latency"}, last_pulse_cyc - t0, DEB * SCAN);
  endtask

  task automatic release_check(input string tag);
    pressed = '0;
    wait_cyc(WAITC);
    chk(kvalid == 1'b0, {tag, " R8 released"}, kvalid, 0);
    chk(kcode == 4'd0 && kchar == 8'h00, {tag, " R8 zero"}, kchar, 0);
  endtask

  initial begin
    int prev_col, run, runs_ok, p0;
    void'($urandom(32'd2024));
    wait_cyc(3);
    chk(col_n == 4'b0111, "R1 reset column", col_n, 7);
    chk(kvalid == 0 && kpulse == 0 && kcode == 0, "R10 reset outputs", kvalid, 0);
    rst_n = 1'b1;

    // R2: column order and step length
    prev_col = 3; run = 0; runs_ok = 1;
    for (int i = 0; i < 6 * SCAN; i++) begin
      int cur;
      @(negedge clk);
      cur = -1;
      for (int c = 0; c < 4; c++) if (!col_n[c]) cur = c;
      if (cur != prev_col) begin
        if (cur != (prev_col + 3) % 4) runs_ok = 0;
        if (i > SETTLE + 1 && run != SETTLE + 1) runs_ok = 0;
        run = 1;
        prev_col = cur;
      end else run++;
    end
    chk(runs_ok == 1, "R2 order and step length", runs_ok, 1);
    chk($countones(~col_n) == 1, "R1 one column low", $countones(~col_n), 1);

    // directed corners
    press_check(16'h0001 << 0, "key0");
    release_check("key0");
    press_check(16'h0001 << 15, "key15");
    release_check("key15");
    press_check(16'h0001 << 13, "key13");
    release_check("key13");
    // R9: different columns, earlier column wins
    press_check((16'h1 << 5) | (16'h1 << 14), "multi col");
    release_check("multi col");
    // R9: same column, lower row wins
    press_check((16'h1 << 2) | (16'h1 << 6), "multi row");
    release_check("multi row");

    // R7: switch to another key while held
    press_check(16'h1 << 0, "hold");
    p0 = pulses;
    pressed = 16'h1 << 5;
    wait_cyc(WAITC);
    chk(pulses == p0 && kcode == 4'd0 && kvalid, "R7 other key ignored", kcode, 0);
    release_check("hold");

    // R5: short bounce, one scan closed then open, repeated
    p0 = pulses;
    for (int i = 0; i < 4; i++) begin
      pressed = 16'h1 << 9;
      wait_cyc(SCAN);
      pressed = '0;
      wait_cyc(SCAN);
    end
    wait_cyc(WAITC);
    chk(pulses == p0 && kvalid == 0, "R5 bounce rejected", pulses - p0, 0);

    // random keys
    for (int i = 0; i < 12; i++) begin
      int k = $urandom_range(15);
      press_check(16'h1 << k, "random");
      release_check("random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule